// File: doc/BRIEF.md
# Acquisition Barrier Synchronizer

This block paces repeated measurement cycles across a set of external instruments that share one trigger line. A single trigger pulse starts integration on every instrument at once. Each instrument then reports the end of its integration with a completion edge, which the surrounding system can also use to fetch that instrument's newest sample. The block holds back the next trigger until every participating channel has reported in the current cycle. Cycling then continues without limit until it is stopped.

A per-channel enable mask selects the channels that take part. A programmable timeout closes a cycle when an instrument stays silent, and the channels that failed to report are recorded. A step-and-hold input parks the block after each completed cycle until a resume command arrives. Completion inputs may be asynchronous to the block clock.

Top module: `acq_barrier`

## Requirements
- R1: In IDLE, a `start` pulse makes `trig_out` high in the next cycle. Every trigger pulse lasts `trig_width` cycles, and a width of 0 gives one cycle.
- R2: Each `chan_done_raw` bit passes through two synchronizing flops, and only its rising edge counts. A level held high counts once. The last input change that closes a cycle raises `trig_out` four clock edges after it is applied.
- R3: After a trigger pulse ends, no new trigger is issued until every enabled channel has shown a completion edge in that cycle. A timeout is the only exception.
- R4: A channel whose `chan_enable` bit is 0 counts as complete. With all bits 0, triggers repeat with one cycle low between pulses.
- R5: When `timeout_cycles` is not 0 and the block has waited that many cycles without all completions, the cycle closes and `timeout_flag` is set. The flag stays set until the next accepted `start`. A value of 0 disables the timeout.
- R6: At every cycle close, `missing_mask` takes the enabled channels that had not completed. It is all zeros when none were missing, and it is cleared by an accepted `start`.
- R7: Completion edges that are seen while `trig_out` is high are ignored and do not count toward the next cycle.
- R8: `cycle_count` (32 bits, modulo) is set to 1 by an accepted `start` and increments by one at the start of each later trigger pulse. It changes at no other time.
- R9: When `hold_mode` is high at a cycle close, the block parks. `parked` goes high and `trig_out` stays low until a `resume` pulse, after which the trigger rises in the next cycle.
- R10: A `stop` during a trigger pulse lets that pulse finish and then returns the block to IDLE. A `stop` while waiting or parked returns it to IDLE in the next cycle. `start` is ignored unless the block is IDLE.
- R11: After reset, `trig_out`, `parked`, `cycle_count`, `timeout_flag` and `missing_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_done_raw | input | NCH | Asynchronous completion signals, one per instrument |
| chan_enable | input | NCH | Channels taking part in the barrier |
| timeout_cycles | input | TMO_W | Wait limit per cycle in clocks, 0 = none |
| trig_width | input | PW_W | Trigger pulse length in clocks, 0 = 1 |
| start | input | 1 | Begin cycling (accepted in IDLE only) |
| stop | input | 1 | End cycling after any pulse in progress |
| hold_mode | input | 1 | Park after each cycle close |
| resume | input | 1 | Leave the parked state and trigger |
| trig_out | output | 1 | Shared trigger to all instruments |
| parked | output | 1 | Block is waiting for `resume` |
| cycle_count | output | CNT_W | Triggers issued since start |
| timeout_flag | output | 1 | A cycle has closed by timeout since start |
| missing_mask | output | NCH | Enabled channels silent at the last close |

## Verification
The assertions assume that `trig_width` changes only while the block is IDLE. The pulse-length check compares against its current value, so a change during a pulse would make the check fire on a correct design. They also assume that `start`, `stop` and `resume` are treated as level commands sampled each clock. The stimulus therefore changes the pulse width only between runs and drives each command high for a single cycle. It changes `chan_enable` only when no completion edge is pending, so the reference model and the design see the same mask at every close.

// File: rtl/acq_sync_pkg.sv
// Shared types for the acquisition barrier synchronizer.
// Assumes nothing beyond a two-bit state encoding.
package acq_sync_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TRIG = 2'd1,
        ST_WAIT = 2'd2,
        ST_HOLD = 2'd3
    } bar_state_t;
endpackage

// File: rtl/cmp_edge_sync.sv
// Synchronizes each asynchronous completion input with two flops and
// emits a one-cycle pulse on its rising edge. Assumes inputs are
// clean levels; glitches shorter than a clock may be lost.
module cmp_edge_sync #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] raw,
    output logic [NCH-1:0] rise
);
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_chan
            logic [2:0] sh;
            // Shift the input through two sync stages plus one history stage.
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= 3'b000;
                else        sh <= {sh[1:0], raw[g]};
            end
            assign rise[g] = sh[1] & ~sh[2];
        end
    endgenerate
endmodule

// File: rtl/cmp_sticky.sv
// Holds one sticky bit per channel for the current cycle. Bits clear
// while the trigger is active, which also discards edges in that time.
// Assumes rise is a synchronous single-cycle pulse per edge.
module cmp_sticky #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] rise,
    input  logic [NCH-1:0] enable,
    input  logic           clr,
    output logic           all_done,
    output logic [NCH-1:0] missing
);
    logic [NCH-1:0] seen;

    // Collect completion edges; wipe them while the trigger is high.
    always_ff @(posedge clk) begin
        if (!rst_n)   seen <= '0;
        else if (clr) seen <= '0;
        else          seen <= seen | rise;
    end

    assign all_done = &(seen | ~enable);
    assign missing  = enable & ~seen;
endmodule

// File: rtl/wait_timer.sv
// Counts cycles spent waiting and flags when the programmed limit is
// reached. Assumes limit is stable during a wait; a limit of 0 disables.
module wait_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    // Count while waiting, restart outside the wait, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!run)          cnt <= '0;
        else if (cnt != '1)     cnt <= cnt + 1'b1;
    end

    assign expired = run && (limit != '0) && (cnt == limit - 1'b1);
endmodule

// File: rtl/barrier_fsm.sv
// Sequencer for the barrier: IDLE -> TRIG -> WAIT -> (HOLD) -> TRIG.
// Emits single-cycle events for trigger starts, run starts and cycle
// closes. Assumes width is stable while not idle.
module barrier_fsm
    import acq_sync_pkg::*;
#(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            stop,
    input  logic            resume,
    input  logic            hold_mode,
    input  logic            all_done,
    input  logic            expired,
    input  logic [PW_W-1:0] width,
    output bar_state_t      state,
    output logic            trig_start,
    output logic            run_start,
    output logic            close_evt,
    output logic            close_tmo
);
    bar_state_t      nxt;
    logic [PW_W-1:0] pw_cnt;
    logic [PW_W-1:0] pw_last;
    logic            stop_pend;

    assign pw_last = (width == '0) ? '0 : width - 1'b1;

    // Next-state and event decode.
    always_comb begin
        nxt        = state;
        trig_start = 1'b0;
        run_start  = 1'b0;
        close_evt  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt        = ST_TRIG;
                    trig_start = 1'b1;
                    run_start  = 1'b1;
                end
            end
            ST_TRIG: begin
                if (pw_cnt == pw_last)
                    nxt = (stop_pend || stop) ? ST_IDLE : ST_WAIT;
            end
            ST_WAIT: begin
                if (stop) begin
                    nxt = ST_IDLE;
                end else if (all_done || expired) begin
                    close_evt = 1'b1;
                    if (hold_mode) begin
                        nxt = ST_HOLD;
                    end else begin
                        nxt        = ST_TRIG;
                        trig_start = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (stop) begin
                    nxt = ST_IDLE;
                end else if (resume) begin
                    nxt        = ST_TRIG;
                    trig_start = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign close_tmo = close_evt && !all_done;

    // State, pulse-length counter and pending-stop register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pw_cnt    <= '0;
            stop_pend <= 1'b0;
        end else begin
            state     <= nxt;
            pw_cnt    <= (state == ST_TRIG && nxt == ST_TRIG) ? pw_cnt + 1'b1 : '0;
            stop_pend <= (state == ST_TRIG && nxt == ST_TRIG) ? (stop_pend | stop) : 1'b0;
        end
    end
endmodule

// File: rtl/acq_barrier.sv
// Top of the acquisition barrier synchronizer. Joins the edge
// synchronizers, sticky collector, wait timer and sequencer, and keeps
// the status registers. Assumes a single clock domain apart from the
// completion inputs.
module acq_barrier
    import acq_sync_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int TMO_W = 16,
    parameter int PW_W  = 8,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   chan_done_raw,
    input  logic [NCH-1:0]   chan_enable,
    input  logic [TMO_W-1:0] timeout_cycles,
    input  logic [PW_W-1:0]  trig_width,
    input  logic             start,
    input  logic             stop,
    input  logic             hold_mode,
    input  logic             resume,
    output logic             trig_out,
    output logic             parked,
    output logic [CNT_W-1:0] cycle_count,
    output logic             timeout_flag,
    output logic [NCH-1:0]   missing_mask
);
    bar_state_t     state;
    logic [NCH-1:0] rise;
    logic [NCH-1:0] miss_now;
    logic           all_done;
    logic           expired;
    logic           trig_start;
    logic           run_start;
    logic           close_evt;
    logic           close_tmo;

    cmp_edge_sync #(.NCH(NCH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (chan_done_raw),
        .rise (rise)
    );

    cmp_sticky #(.NCH(NCH)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .enable  (chan_enable),
        .clr     (trig_out),
        .all_done(all_done),
        .missing (miss_now)
    );

    wait_timer #(.TMO_W(TMO_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_WAIT),
        .limit  (timeout_cycles),
        .expired(expired)
    );

    barrier_fsm #(.PW_W(PW_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .resume    (resume),
        .hold_mode (hold_mode),
        .all_done  (all_done),
        .expired   (expired),
        .width     (trig_width),
        .state     (state),
        .trig_start(trig_start),
        .run_start (run_start),
        .close_evt (close_evt),
        .close_tmo (close_tmo)
    );

    assign trig_out = (state == ST_TRIG);
    assign parked   = (state == ST_HOLD);

    // Cycle counter: restart at one on a run start, step on each trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)          cycle_count <= '0;
        else if (run_start)  cycle_count <= CNT_W'(1);
        else if (trig_start) cycle_count <= cycle_count + 1'b1;
    end

    // Sticky timeout flag and missing-channel capture at each close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_flag <= 1'b0;
            missing_mask <= '0;
        end else if (run_start) begin
            timeout_flag <= 1'b0;
            missing_mask <= '0;
        end else if (close_evt) begin
            timeout_flag <= timeout_flag | close_tmo;
            missing_mask <= miss_now;
        end
    end
endmodule

// File: rtl/acq_barrier_chk.sv
// Property checker for acq_barrier, attached by bind below. Assumes
// trig_width changes only while idle.
module acq_barrier_chk #(
    parameter int PW_W  = 8,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop,
    input logic             resume,
    input logic [PW_W-1:0]  trig_width,
    input logic             trig_out,
    input logic             parked,
    input logic [CNT_W-1:0] cycle_count,
    input logic             timeout_flag
);
    logic [PW_W:0] hi_len;
    logic [PW_W:0] want_len;

    // Length of the current trigger pulse so far.
    always_ff @(posedge clk) begin
        if (!rst_n)        hi_len <= '0;
        else if (trig_out) hi_len <= hi_len + 1'b1;
        else               hi_len <= '0;
    end

    assign want_len = (trig_width == '0) ? (PW_W+1)'(1) : {1'b0, trig_width};

    a_r1_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trig_out) |-> hi_len == want_len);

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_out) |-> (cycle_count == $past(cycle_count) + 1'b1) || (cycle_count == CNT_W'(1)));

    a_r8_count_only_on_trig: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cycle_count) |-> $rose(trig_out));

    a_r5_flag_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> (trig_out || parked));

    a_r9_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        parked |-> !trig_out);

    a_r9_resume_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (parked && resume && !stop) |=> trig_out);

    a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !trig_out) |=> (!trig_out && !parked));
endmodule

bind acq_barrier acq_barrier_chk #(.PW_W(PW_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop        (stop),
    .resume      (resume),
    .trig_width  (trig_width),
    .trig_out    (trig_out),
    .parked      (parked),
    .cycle_count (cycle_count),
    .timeout_flag(timeout_flag)
);

// File: tb/sim_acq_barrier.sv
module sim_acq_barrier;
    localparam int NCH = 4;
    localparam int TMO_W = 16;
    localparam int PW_W = 8;
    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   chan_done_raw = '0;
    logic [NCH-1:0]   chan_enable = '0;
    logic [TMO_W-1:0] timeout_cycles = '0;
    logic [PW_W-1:0]  trig_width = '0;
    logic             start = 1'b0, stop = 1'b0, hold_mode = 1'b0, resume = 1'b0;
    logic             trig_out, parked, timeout_flag;
    logic [CNT_W-1:0] cycle_count;
    logic [NCH-1:0]   missing_mask;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    acq_barrier #(.NCH(NCH), .TMO_W(TMO_W), .PW_W(PW_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_done_raw(chan_done_raw), .chan_enable(chan_enable),
        .timeout_cycles(timeout_cycles), .trig_width(trig_width), .start(start), .stop(stop),
        .hold_mode(hold_mode), .resume(resume), .trig_out(trig_out), .parked(parked),
        .cycle_count(cycle_count), .timeout_flag(timeout_flag), .missing_mask(missing_mask)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int               m_st;      // 0 idle, 1 trig, 2 wait, 3 hold
    int               m_pw, m_wc;
    bit               m_pend;
    logic [NCH-1:0]   m_seen;
    logic [NCH-1:0]   m_miss;
    bit               m_flag;
    longint           m_cnt;
    logic [NCH-1:0]   hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pw = 0; m_wc = 0; m_pend = 0; m_seen = '0; m_miss = '0;
            m_flag = 0; m_cnt = 0;
            hist = '{'0, '0, '0};
        end else begin
            logic [NCH-1:0] ed;
            bit done, tmo;
            int eff, old;
            ed = hist[1] & ~hist[2];
            hist.push_front(chan_done_raw);
            void'(hist.pop_back());
            done = ((m_seen | ~chan_enable) == '1);
            tmo = (timeout_cycles != 0) && (m_wc == int'(timeout_cycles) - 1);
            eff = (trig_width == 0) ? 1 : int'(trig_width);
            old = m_st;
            case (m_st)
                0: if (start) begin
                       m_st = 1; m_pw = 0; m_cnt = 1; m_flag = 0; m_miss = '0; m_pend = 0;
                   end
                1: if (m_pw == eff - 1) begin
                       m_st = (m_pend || stop) ? 0 : 2; m_pend = 0; m_wc = 0;
                   end else begin
                       m_pw++; if (stop) m_pend = 1;
                   end
                2: if (stop) m_st = 0;
                   else if (done || tmo) begin
                       if (!done) m_flag = 1;
                       m_miss = chan_enable & ~m_seen;
                       if (hold_mode) m_st = 3;
                       else begin m_st = 1; m_pw = 0; m_cnt = (m_cnt + 1) % (64'd1 << CNT_W); end
                   end else m_wc++;
                default: if (stop) m_st = 0;
                   else if (resume) begin m_st = 1; m_pw = 0; m_cnt = (m_cnt + 1) % (64'd1 << CNT_W); end
            endcase
            if (old == 1) m_seen = '0;
            else m_seen = m_seen | ed;
        end
    end

    // Compare the design against the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(trig_out == (m_st == 1), "R3 model trig_out", trig_out, m_st == 1);
            check(parked == (m_st == 3), "R9 model parked", parked, m_st == 3);
            check(cycle_count == m_cnt, "R8 model cycle_count", cycle_count, m_cnt);
            check(timeout_flag == m_flag, "R5 model timeout_flag", timeout_flag, m_flag);
            check(missing_mask == m_miss, "R6 model missing_mask", missing_mask, m_miss);
        end
    end

    // ---------------- directed helpers ----------------
    task automatic tick(); @(negedge clk); endtask

    task automatic pulse_done(input logic [NCH-1:0] m);
        chan_done_raw = m; tick(); tick(); chan_done_raw = '0;
    endtask

    task automatic wait_trig(output int n);
        n = 0;
        while (!trig_out && n < 5000) begin tick(); n++; end
    endtask

    task automatic high_len(output int n);
        n = 0;
        while (trig_out && n < 5000) begin tick(); n++; end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int n;
        logic [CNT_W-1:0] c0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R11: reset state
        check(!trig_out && !parked, "R11 outputs idle", trig_out, 0);
        check(cycle_count == 0 && !timeout_flag && missing_mask == 0, "R11 status clear", cycle_count, 0);

        // R1: start and pulse width
        chan_enable = 4'b1111; trig_width = 8'd8; timeout_cycles = '0;
        start = 1; tick(); start = 0;
        check(trig_out == 1, "R1 trigger after start", trig_out, 1);
        check(cycle_count == 1, "R8 count after start", cycle_count, 1);
        high_len(n);
        check(n == 8, "R1 pulse width 8", n, 8);

        // R3/R5 (disabled): no trigger without completions
        repeat (10) tick();
        check(!trig_out, "R5 no timeout when limit is 0", trig_out, 0);
        // R2: held levels on three channels count once, still waiting
        chan_done_raw = 4'b0111;
        repeat (10) tick();
        check(!trig_out, "R3 barrier waits for channel 3", trig_out, 0);
        chan_done_raw = 4'b1111;
        wait_trig(n);
        check(n == 4, "R2 close latency four edges", n, 4);
        check(cycle_count == 2, "R8 count step", cycle_count, 2);
        check(missing_mask == 0, "R6 nothing missing", missing_mask, 0);

        // R7: edges during trigger are ignored
        chan_done_raw = '0; tick(); chan_done_raw = 4'b1111; tick(); tick(); chan_done_raw = '0;
        high_len(n);
        repeat (20) tick();
        check(!trig_out, "R7 edges during pulse ignored", trig_out, 0);
        pulse_done(4'b1111);
        wait_trig(n);
        check(cycle_count == 3, "R3 close after fresh edges", cycle_count, 3);
        high_len(n);

        // R4: disabled channels count as complete
        chan_enable = 4'b0101;
        pulse_done(4'b0001);
        repeat (10) tick();
        check(!trig_out, "R4 channel 2 still needed", trig_out, 0);
        pulse_done(4'b0100);
        wait_trig(n);
        check(trig_out == 1 && cycle_count == 4, "R4 masked channels skipped", cycle_count, 4);
        high_len(n);
        chan_enable = 4'b1111;

        // R5/R6: timeout closes the cycle
        timeout_cycles = 16'd30;
        chan_done_raw = 4'b0011;
        n = 0;
        while (!trig_out && n < 5000) begin n++; tick(); end
        check(n == 30, "R5 timeout wait length", n, 30);
        check(timeout_flag == 1, "R5 flag set", timeout_flag, 1);
        check(missing_mask == 4'b1100, "R6 missing channels", missing_mask, 4'b1100);
        chan_done_raw = '0;
        high_len(n);
        pulse_done(4'b1111);
        wait_trig(n);
        check(missing_mask == 0, "R6 mask cleared at good close", missing_mask, 0);
        check(timeout_flag == 1, "R5 flag sticky", timeout_flag, 1);
        timeout_cycles = '0;
        high_len(n);

        // R9: step and hold
        hold_mode = 1;
        pulse_done(4'b1111);
        repeat (10) tick();
        c0 = cycle_count;
        check(parked == 1 && !trig_out, "R9 parked after close", parked, 1);
        repeat (5) tick();
        check(cycle_count == c0 && !trig_out, "R9 holds without trigger", cycle_count, c0);
        resume = 1; tick(); resume = 0;
        check(trig_out == 1 && !parked, "R9 resume triggers", trig_out, 1);
        check(cycle_count == c0 + 1, "R8 count on resume", cycle_count, c0 + 1);
        hold_mode = 0;

        // R10: stop during pulse finishes the pulse then idles
        stop = 1; tick(); stop = 0;
        high_len(n);
        check(n == 7, "R10 pulse completes after stop", n + 1, 8);
        pulse_done(4'b1111);
        repeat (20) tick();
        check(!trig_out && !parked, "R10 idle after stop", trig_out, 0);

        // R1 width 0, R4 all disabled, R8 restart
        trig_width = '0; chan_enable = '0;
        start = 1; tick(); start = 0;
        check(trig_out == 1 && cycle_count == 1, "R8 restart count", cycle_count, 1);
        check(timeout_flag == 0, "R5 flag cleared by start", timeout_flag, 0);
        tick();
        check(!trig_out, "R1 width 0 gives one cycle", trig_out, 0);
        c0 = cycle_count;
        repeat (20) tick();
        check(cycle_count == c0 + 10, "R4 back-to-back triggers", cycle_count, c0 + 10);
        start = 1; tick(); start = 0;
        check(cycle_count != 1, "R10 start ignored while running", cycle_count, 0);
        stop = 1; tick(); stop = 0;
        repeat (4) tick();
        check(!trig_out, "R10 stopped", trig_out, 0);
        finish_run();
    end
endmodule